// File: doc/BRIEF.md
# Bit-Serial Loaded Square-and-Multiply Exponentiator

This block raises an unsigned base A to an unsigned exponent B and keeps the result modulo 2^W. Both operands are loaded one bit per clock through a three-wire shift port. While the chip-select input is high, each clock shifts the data pin into either the base or the exponent register, most significant bit first. The select pin chooses which register receives the bit. While chip select is high, computation is frozen.

When chip select falls, the unit sets its result to one, copies the loaded base into a working base register and the loaded exponent into a working exponent register. After that it processes one exponent bit on every clock, starting with the least significant bit. When that bit is one, the result is multiplied by the working base. When it is zero, the result is multiplied by one. On every processing cycle the working base is squared and the working exponent is shifted right. Every product is truncated to W bits.

The block has no completion flag. When the working exponent reaches zero, each further cycle multiplies the result by one. The output therefore becomes final at most N processing cycles after the start and stays constant until the next load. Two multiplier forms are available through a parameter. One is an inferred multiply. The other is an unrolled shift-and-add array.

Top module: `expo_unit`

## Requirements
- R1: After a synchronous active-high reset, result_o is 1.
- R2: While cs_i is 1, each clock shifts data_i into the least significant bit of the base operand register when sel_i is 0, and of the exponent operand register when sel_i is 1. Earlier bits move toward the most significant end, so an operand is sent MSB first.
- R3: While cs_i is 1, result_o does not change.
- R4: On the first clock with cs_i at 0 after a clock with cs_i at 1, the result register is loaded with 1. result_o therefore reads 1 after that edge.
- R5: Starting N+1 clocks after that first clock with cs_i at 0, result_o equals A^B mod 2^W. A and B are the last N bits shifted into the respective registers.
- R6: When B is 0, the final result is 1, and this includes A equal to 0.
- R7: When the computation has finished and cs_i stays 0, result_o keeps its value on every following clock.
- R8: If more than N bits are shifted into one register, only the last N bits are kept.
- R9: Products are truncated to the low W bits, so bases whose powers exceed 2^W give the result modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for loading and computing |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | High while loading; a falling level starts computation |
| sel_i | input | 1 | 0 shifts into the base, 1 shifts into the exponent |
| data_i | input | 1 | Serial operand bit |
| result_o | output | W | Running and final result, modulo 2^W |

## Verification
The assertions check on every cycle that a shift places the data pin into the selected operand register. They also check that chip select freezes the result and the working exponent, that a start leaves the result at one, that the working exponent halves on each processing cycle, and that a zero exponent holds the result. Whether the final value is actually A^B mod 2^W, including the zero-exponent, zero-base, over-length load and truncation cases, is shown only by the bench. The bench sweeps every operand pair of a small configuration against a reference computed by repeated multiplication.

// File: rtl/expo_pkg.sv
package expo_pkg;

    // Target of a serial shift while chip select is high
    typedef enum logic {
        TGT_BASE = 1'b0,
        TGT_EXP  = 1'b1
    } tgt_e;

    // Multiplier implementation variant
    localparam int MUL_INFERRED = 0;
    localparam int MUL_SHIFTADD = 1;

endpackage

// File: rtl/expo_mul.sv
module expo_mul #(
    parameter int W     = 64,
    parameter int STYLE = 0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);
    import expo_pkg::*;

    generate
        if (STYLE == MUL_SHIFTADD) begin : g_shiftadd
            logic [W-1:0] acc [W+1];
            assign acc[0] = '0;
            for (genvar i = 0; i < W; i++) begin : g_row
                logic [W-1:0] row;
                assign row      = b_i[i] ? (a_i << i) : '0;
                assign acc[i+1] = acc[i] + row;
            end
            assign p_o = acc[W];
        end else begin : g_inferred
            assign p_o = a_i * b_i;
        end
    endgenerate

endmodule

// File: rtl/expo_loader.sv
module expo_loader #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_i,
    input  logic         sel_i,
    input  logic         data_i,
    output logic [N-1:0] a_o,
    output logic [N-1:0] b_o,
    output logic         hold_o,
    output logic         start_o
);
    import expo_pkg::*;

    typedef struct packed {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic         cs_prev;
    } ld_s;

    ld_s st_d, st_q;
    tgt_e tgt;

    assign tgt = tgt_e'(sel_i);

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = cs_i;
        if (cs_i) begin
            if (tgt == TGT_BASE) st_d.a = {st_q.a[N-2:0], data_i};
            else                 st_d.b = {st_q.b[N-2:0], data_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_o     = st_q.a;
    assign b_o     = st_q.b;
    assign hold_o  = cs_i;
    assign start_o = st_q.cs_prev & ~cs_i;

    // R2
    shift_base_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_i && !sel_i) |=> (a_o[0] == $past(data_i)) && $stable(b_o));
    // R2
    shift_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_i && sel_i) |=> (b_o[0] == $past(data_i)) && $stable(a_o));

endmodule

// File: rtl/expo_core.sv
module expo_core #(
    parameter int N         = 16,
    parameter int W         = 64,
    parameter int MUL_STYLE = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_i,
    input  logic         start_i,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [W-1:0] result_o
);
    localparam logic [W-1:0] ONE_W = W'(1);

    typedef struct packed {
        logic [W-1:0] base;
        logic [N-1:0] expo;
        logic [W-1:0] res;
    } core_s;

    core_s st_d, st_q;
    logic [W-1:0] factor;
    logic [W-1:0] res_prod;
    logic [W-1:0] sq_prod;

    // Multiply by the base power when the current exponent bit is set, else by one
    assign factor = st_q.expo[0] ? st_q.base : ONE_W;

    expo_mul #(.W(W), .STYLE(MUL_STYLE)) u_mul_res (
        .a_i (st_q.res),
        .b_i (factor),
        .p_o (res_prod)
    );

    expo_mul #(.W(W), .STYLE(MUL_STYLE)) u_mul_sq (
        .a_i (st_q.base),
        .b_i (st_q.base),
        .p_o (sq_prod)
    );

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d = st_q;
        end else if (start_i) begin
            st_d.res  = ONE_W;
            st_d.base = W'(a_i);
            st_d.expo = b_i;
        end else begin
            st_d.res  = res_prod;
            st_d.base = sq_prod;
            st_d.expo = st_q.expo >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.base <= '0;
            st_q.expo <= '0;
            st_q.res  <= ONE_W;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.res;

    // R3
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(st_q.res) && $stable(st_q.expo));
    // R4
    start_one_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !hold_i) |=> (st_q.res == ONE_W));
    // R5
    expo_halve_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !start_i) |=> (st_q.expo == ($past(st_q.expo) >> 1)));
    // R7
    done_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !start_i && st_q.expo == '0) |=> $stable(st_q.res));

endmodule

// File: rtl/expo_unit.sv
module expo_unit #(
    parameter int N         = 16,
    parameter int W         = 64,
    parameter int MUL_STYLE = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_i,
    input  logic         sel_i,
    input  logic         data_i,
    output logic [W-1:0] result_o
);
    logic [N-1:0] a_w;
    logic [N-1:0] b_w;
    logic         hold_w;
    logic         start_w;

    expo_loader #(.N(N)) u_loader (
        .clk     (clk),
        .rst     (rst),
        .cs_i    (cs_i),
        .sel_i   (sel_i),
        .data_i  (data_i),
        .a_o     (a_w),
        .b_o     (b_w),
        .hold_o  (hold_w),
        .start_o (start_w)
    );

    expo_core #(.N(N), .W(W), .MUL_STYLE(MUL_STYLE)) u_core (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (hold_w),
        .start_i  (start_w),
        .a_i      (a_w),
        .b_i      (b_w),
        .result_o (result_o)
    );

    // R1
    reset_one_chk: assert property (@(posedge clk)
        rst |=> (result_o == W'(1)));

endmodule

// File: tb/expo_unit_tb.sv
module expo_unit_tb;
    localparam int N = 4;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0;
    logic sel = 1'b0;
    logic din = 1'b0;
    logic [W-1:0] res;

    int checks = 0;
    int failures = 0;

    expo_unit #(.N(N), .W(W), .MUL_STYLE(1)) u_dut (
        .clk(clk), .rst(rst), .cs_i(cs), .sel_i(sel), .data_i(din), .result_o(res)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] ref_pow(int a, int b);
        logic [W-1:0] r = W'(1);
        for (int i = 0; i < b; i++) r = r * W'(a);
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Shift nb bits of val MSB first into target t; checks result frozen (R3)
    task automatic shift_in(logic t, int val, int nb, logic [W-1:0] frozen);
        for (int i = nb - 1; i >= 0; i--) begin
            cs = 1'b1; sel = t; din = val[i];
            tick();
            check("R3", res, frozen);
        end
    endtask

    task automatic run(int a, int b, int nb, string req);
        logic [W-1:0] prev;
        logic [W-1:0] expv;
        prev = res;
        shift_in(1'b0, a, nb, prev);
        shift_in(1'b1, b, nb, prev);
        cs = 1'b0;
        tick();
        check("R4", res, W'(1));
        for (int i = 0; i < N; i++) tick();
        expv = ref_pow(a % (1 << N), b % (1 << N));
        check(req, res, expv);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R7", res, expv);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1", res, W'(1));
        // R6: zero exponent, including 0^0
        run(0, 0, N, "R6");
        run(9, 0, N, "R6");
        // R8: extra leading bits are shifted out
        run(6'b110101, 6'b100011, N + 2, "R8");
        // R9: 15^15 exceeds 2^8
        run(15, 15, N, "R9");
        // R2 / R5: exhaustive sweep
        for (int a = 0; a < (1 << N); a++)
            for (int b = 0; b < (1 << N); b++)
                run(a, b, N, (b == 1) ? "R2" : "R5");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule